// File: doc/BRIEF.md
# Vector Memory DMA Controller

The block owns a small two-dimensional scratch memory of 64 rows by 16 columns of 32-bit words. The processing cores share this memory. The block moves rectangular regions of it to and from an external word-wide memory. Loads and stores each have their own three ports. A setup port takes 32-bit configuration words, and bit 31 of each word sends it either to the DMA engine for that direction or to the core-side access pointer. An address port takes the external byte address, and accepting it starts the transfer. A wait port answers only when no transfer is in flight for that direction, so a core that reads it stalls until its data has landed or has left.

The core-side pointers walk the scratch memory either along a row or down a column, with a programmable step. The read pointer is configured through the load setup port and serves `core_rd_data`. The write pointer is configured through the store setup port and consumes `core_wr_data`. The DMA engines copy a block of up to 64 by 16 words. The external address rises by 4 bytes per word, and a programmable extra stride is added at the end of every block row. One request/acknowledge port to external memory is shared between the two directions.

Top module: `vmd_dma`

## Requirements
- R1: During and right after reset, `ext_req` is 0 and both address ports are ready. The block config is a 1x1 block at row 0, column 0, with extra stride 0. Both core pointers sit at row 0, column 0, stepping along the row by 1.
- R2: A setup word with bit 31 = 1 changes only that direction's DMA configuration and leaves the core pointer where it was. A word with bit 31 = 0 changes only the core pointer of that direction and leaves the DMA configuration as it was.
- R3: A core pointer word (bit 31 = 0) holds the start row in [5:0], the start column in [9:6], the mode in bit 10 (1 = along the row) and the step in [16:11]. In row mode, each access moves the column by the step modulo 16 and leaves the row unchanged.
- R4: In column mode (bit 10 = 0), each access moves the row by the step modulo 64 and leaves the column unchanged. `core_rd_data` always shows the word at the read pointer.
- R5: A DMA block word has bit 31 = 1 and bit 30 = 0. It holds the start row in [5:0], the start column in [9:6], the row count minus 1 in [15:10] and the column count minus 1 in [19:16]. Word (r, c) of the block maps to scratch row (row0 + r) mod 64 and column (col0 + c) mod 16. Words are moved row by row, with columns in rising order.
- R6: A stride word has bits 31:30 = 11 and sets the extra stride in [15:0]. The extra stride starts at 0. The external address starts at the written base, rises by 4 after every word, and additionally rises by the extra stride after the last word of each block row.
- R7: Accepting an address starts a transfer. The address port of that direction stays not-ready until its last word is acknowledged, so a second address is held back until then.
- R8: `*_wait_done` is 1 only while `*_wait_req` is 1 and that direction has no transfer in flight.
- R9: While `ext_req` is 1 and `ext_ack` is 0, `ext_addr` and `ext_we` hold steady. Each acknowledge completes one word, and `ext_req` is 0 in the cycle after an acknowledge.
- R10: A load (`ext_we` = 0) writes `ext_rdata` into the mapped scratch word. A store (`ext_we` = 1) presents the mapped scratch word on `ext_wdata`.
- R11: When both directions want the external port, the load is served first.
- R12: The engine captures its configuration when a transfer starts. Setup words written during a transfer apply only to the next transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_setup_valid | input | 1 | Load-side setup word strobe |
| ld_setup_data | input | 32 | Load DMA config (bit 31 = 1) or core read pointer config |
| ld_addr_valid | input | 1 | Load external base address offered |
| ld_addr_data | input | 32 | Load external byte address |
| ld_addr_ready | output | 1 | Load engine idle, address accepted |
| ld_wait_req | input | 1 | Core waits for load completion |
| ld_wait_done | output | 1 | Load wait released |
| st_setup_valid | input | 1 | Store-side setup word strobe |
| st_setup_data | input | 32 | Store DMA config (bit 31 = 1) or core write pointer config |
| st_addr_valid | input | 1 | Store external base address offered |
| st_addr_data | input | 32 | Store external byte address |
| st_addr_ready | output | 1 | Store engine idle, address accepted |
| st_wait_req | input | 1 | Core waits for store completion |
| st_wait_done | output | 1 | Store wait released |
| core_rd_en | input | 1 | Advance core read pointer |
| core_rd_data | output | 32 | Scratch word at core read pointer |
| core_wr_en | input | 1 | Write at core write pointer and advance it |
| core_wr_data | input | 32 | Core write data |
| ext_req | output | 1 | External word request |
| ext_we | output | 1 | 1 = write (store), 0 = read (load) |
| ext_addr | output | 32 | External byte address |
| ext_wdata | output | 32 | External write data |
| ext_ack | input | 1 | External word acknowledge |
| ext_rdata | input | 32 | External read data, valid with ack |

## Verification
A wrong engine counter or a wrong snapshot of the config shows up on the first wrong `ext_addr` or at a misplaced scratch word. An address error is visible within one word of the fault. A placement error is seen only when a core pointer later reads that location. A stuck busy flag keeps the address port not-ready and the wait port silent, which the bench sees as a hang. A wrong pointer step is caught by row- and column-wise read sweeps over the whole memory, at the first access after the faulty step.

// File: rtl/vmd_pkg.sv
// Shared sizes, setup word field positions and configuration types for the
// vector memory DMA controller. Row and column counts must be powers of two
// so that a scratch index is the concatenation {row, col}.
package vmd_pkg;
    localparam int SCR_ROWS   = 64;
    localparam int SCR_COLS   = 16;
    localparam int ROW_W      = $clog2(SCR_ROWS);
    localparam int COL_W      = $clog2(SCR_COLS);
    localparam int IDX_W      = ROW_W + COL_W;
    localparam int STRIDE_W   = 16;
    localparam int WORD_W     = 32;
    localparam int ADDR_STEP  = WORD_W / 8;

    // setup word decode positions
    localparam int SEL_BIT    = 31;
    localparam int SUB_BIT    = 30;
    localparam int F_ROW_LO   = 0;
    localparam int F_COL_LO   = ROW_W;
    localparam int F_NR_LO    = ROW_W + COL_W;
    localparam int F_NC_LO    = 2 * ROW_W + COL_W;
    localparam int F_MODE_BIT = ROW_W + COL_W;
    localparam int F_STEP_LO  = ROW_W + COL_W + 1;

    typedef struct packed {
        logic [STRIDE_W-1:0] stride;
        logic [COL_W-1:0]    ncols_m1;
        logic [ROW_W-1:0]    nrows_m1;
        logic [COL_W-1:0]    col0;
        logic [ROW_W-1:0]    row0;
    } dma_cfg_t;

    typedef enum logic [1:0] {OWN_NONE, OWN_LD, OWN_ST} ext_owner_e;
endpackage

// File: rtl/vmd_scratch.sv
// Scratch word array with two write ports and two combinational read ports.
// Assumes write port A (DMA) wins over port B (core) on the same index.
module vmd_scratch
    import vmd_pkg::*;
(
    input  logic              clk,
    input  logic              we_a,
    input  logic [IDX_W-1:0]  wa_a,
    input  logic [WORD_W-1:0] wd_a,
    input  logic              we_b,
    input  logic [IDX_W-1:0]  wa_b,
    input  logic [WORD_W-1:0] wd_b,
    input  logic [IDX_W-1:0]  ra_0,
    output logic [WORD_W-1:0] rd_0,
    input  logic [IDX_W-1:0]  ra_1,
    output logic [WORD_W-1:0] rd_1
);
    localparam int WORDS = SCR_ROWS * SCR_COLS;

    logic [WORD_W-1:0] mem_q [WORDS];

    // Store words; the later assignment (port A) takes precedence.
    always_ff @(posedge clk) begin
        if (we_b) mem_q[wa_b] <= wd_b;
        if (we_a) mem_q[wa_a] <= wd_a;
    end

    // Asynchronous reads for the core pointer and the store engine.
    always_comb begin
        rd_0 = mem_q[ra_0];
        rd_1 = mem_q[ra_1];
    end
endmodule

// File: rtl/vmd_setup_dec.sv
// Splits a setup word stream by bit 31: DMA words update the held engine
// configuration (block word or stride word chosen by bit 30); other words
// are passed on as a core pointer load strobe.
module vmd_setup_dec
    import vmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              setup_valid,
    input  logic [WORD_W-1:0] setup_data,
    output logic              ptr_load,
    output dma_cfg_t          dma_cfg
);
    dma_cfg_t cfg_q;

    // Hold DMA configuration; reset gives a 1x1 block at origin, stride 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (setup_valid && setup_data[SEL_BIT]) begin
            if (setup_data[SUB_BIT]) begin
                cfg_q.stride <= setup_data[STRIDE_W-1:0];
            end else begin
                cfg_q.row0     <= setup_data[F_ROW_LO +: ROW_W];
                cfg_q.col0     <= setup_data[F_COL_LO +: COL_W];
                cfg_q.nrows_m1 <= setup_data[F_NR_LO +: ROW_W];
                cfg_q.ncols_m1 <= setup_data[F_NC_LO +: COL_W];
            end
        end
    end

    // Route core-side words to the pointer.
    always_comb begin
        ptr_load = setup_valid && !setup_data[SEL_BIT];
        dma_cfg  = cfg_q;
    end
endmodule

// File: rtl/vmd_access_ptr.sv
// Core-side scratch pointer walking along a row or down a column with a
// programmable step, wrapping within the row or column.
module vmd_access_ptr
    import vmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] cfg_word,
    input  logic              step,
    output logic [IDX_W-1:0]  idx
);
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;
    logic             along_row_q;
    logic [ROW_W-1:0] step_q;

    // Load a new start position and mode, or advance after an access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q       <= '0;
            col_q       <= '0;
            along_row_q <= 1'b1;
            step_q      <= ROW_W'(1);
        end else if (load) begin
            row_q       <= cfg_word[F_ROW_LO +: ROW_W];
            col_q       <= cfg_word[F_COL_LO +: COL_W];
            along_row_q <= cfg_word[F_MODE_BIT];
            step_q      <= cfg_word[F_STEP_LO +: ROW_W];
        end else if (step) begin
            if (along_row_q) col_q <= col_q + step_q[COL_W-1:0];
            else             row_q <= row_q + step_q;
        end
    end

    // Flatten position to a word index.
    always_comb idx = {row_q, col_q};
endmodule

// File: rtl/vmd_xfer_engine.sv
// One-direction block transfer sequencer. Captures its configuration and
// base address on start, then steps one word per completed external beat,
// row by row, adding the extra stride after each block row.
module vmd_xfer_engine
    import vmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  dma_cfg_t          cfg,
    input  logic              addr_valid,
    input  logic [WORD_W-1:0] addr_data,
    output logic              addr_ready,
    output logic              busy,
    input  logic              word_done,
    output logic [WORD_W-1:0] ext_addr,
    output logic [IDX_W-1:0]  scr_idx
);
    dma_cfg_t          act_q;
    logic              busy_q;
    logic [ROW_W-1:0]  r_cnt_q;
    logic [COL_W-1:0]  c_cnt_q;
    logic [WORD_W-1:0] addr_q;
    logic [ROW_W-1:0]  row_w;
    logic [COL_W-1:0]  col_w;

    // Start on an accepted address, then walk the block one word per beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q   <= '0;
            busy_q  <= 1'b0;
            r_cnt_q <= '0;
            c_cnt_q <= '0;
            addr_q  <= '0;
        end else if (!busy_q) begin
            if (addr_valid) begin
                act_q   <= cfg;
                busy_q  <= 1'b1;
                r_cnt_q <= '0;
                c_cnt_q <= '0;
                addr_q  <= addr_data;
            end
        end else if (word_done) begin
            if (c_cnt_q == act_q.ncols_m1) begin
                c_cnt_q <= '0;
                addr_q  <= addr_q + WORD_W'(ADDR_STEP) + WORD_W'(act_q.stride);
                if (r_cnt_q == act_q.nrows_m1) busy_q  <= 1'b0;
                else                           r_cnt_q <= r_cnt_q + 1'b1;
            end else begin
                c_cnt_q <= c_cnt_q + 1'b1;
                addr_q  <= addr_q + WORD_W'(ADDR_STEP);
            end
        end
    end

    // Map block position to scratch index with wrap; expose handshake state.
    always_comb begin
        row_w      = act_q.row0 + r_cnt_q;
        col_w      = act_q.col0 + c_cnt_q;
        scr_idx    = {row_w, col_w};
        ext_addr   = addr_q;
        busy       = busy_q;
        addr_ready = !busy_q;
    end
endmodule

// File: rtl/vmd_dma.sv
// Vector memory DMA controller top: two setup decoders, two core pointers,
// a load and a store engine, the scratch array and a word-granular owner
// register for the shared external port (load preferred, one idle cycle
// after every acknowledged word).
module vmd_dma
    import vmd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ld_setup_valid,
    input  logic [31:0] ld_setup_data,
    input  logic        ld_addr_valid,
    input  logic [31:0] ld_addr_data,
    output logic        ld_addr_ready,
    input  logic        ld_wait_req,
    output logic        ld_wait_done,
    input  logic        st_setup_valid,
    input  logic [31:0] st_setup_data,
    input  logic        st_addr_valid,
    input  logic [31:0] st_addr_data,
    output logic        st_addr_ready,
    input  logic        st_wait_req,
    output logic        st_wait_done,
    input  logic        core_rd_en,
    output logic [31:0] core_rd_data,
    input  logic        core_wr_en,
    input  logic [31:0] core_wr_data,
    output logic        ext_req,
    output logic        ext_we,
    output logic [31:0] ext_addr,
    output logic [31:0] ext_wdata,
    input  logic        ext_ack,
    input  logic [31:0] ext_rdata
);
    dma_cfg_t          ld_cfg, st_cfg;
    logic              rd_ptr_load, wr_ptr_load;
    logic [IDX_W-1:0]  rd_idx, wr_idx, ld_idx, st_idx;
    logic              ld_busy, st_busy, ld_done, st_done;
    logic [WORD_W-1:0] ld_ext_addr, st_ext_addr, st_rdata;
    ext_owner_e        own_q;

    vmd_setup_dec u_ld_dec (.clk, .rst_n, .setup_valid(ld_setup_valid),
        .setup_data(ld_setup_data), .ptr_load(rd_ptr_load), .dma_cfg(ld_cfg));
    vmd_setup_dec u_st_dec (.clk, .rst_n, .setup_valid(st_setup_valid),
        .setup_data(st_setup_data), .ptr_load(wr_ptr_load), .dma_cfg(st_cfg));

    vmd_access_ptr u_rd_ptr (.clk, .rst_n, .load(rd_ptr_load),
        .cfg_word(ld_setup_data), .step(core_rd_en), .idx(rd_idx));
    vmd_access_ptr u_wr_ptr (.clk, .rst_n, .load(wr_ptr_load),
        .cfg_word(st_setup_data), .step(core_wr_en), .idx(wr_idx));

    vmd_xfer_engine u_ld_eng (.clk, .rst_n, .cfg(ld_cfg),
        .addr_valid(ld_addr_valid), .addr_data(ld_addr_data),
        .addr_ready(ld_addr_ready), .busy(ld_busy), .word_done(ld_done),
        .ext_addr(ld_ext_addr), .scr_idx(ld_idx));
    vmd_xfer_engine u_st_eng (.clk, .rst_n, .cfg(st_cfg),
        .addr_valid(st_addr_valid), .addr_data(st_addr_data),
        .addr_ready(st_addr_ready), .busy(st_busy), .word_done(st_done),
        .ext_addr(st_ext_addr), .scr_idx(st_idx));

    vmd_scratch u_mem (.clk,
        .we_a(ld_done), .wa_a(ld_idx), .wd_a(ext_rdata),
        .we_b(core_wr_en), .wa_b(wr_idx), .wd_b(core_wr_data),
        .ra_0(rd_idx), .rd_0(core_rd_data),
        .ra_1(st_idx), .rd_1(st_rdata));

    // Pick the external port owner between words; release after each ack.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_q <= OWN_NONE;
        end else if (own_q == OWN_NONE) begin
            if (ld_busy)      own_q <= OWN_LD;
            else if (st_busy) own_q <= OWN_ST;
        end else if (ext_ack) begin
            own_q <= OWN_NONE;
        end
    end

    // Drive the external port from the owning engine and release waits.
    always_comb begin
        ext_req      = own_q != OWN_NONE;
        ext_we       = own_q == OWN_ST;
        ext_addr     = ext_we ? st_ext_addr : ld_ext_addr;
        ext_wdata    = st_rdata;
        ld_done      = (own_q == OWN_LD) && ext_ack;
        st_done      = (own_q == OWN_ST) && ext_ack;
        ld_wait_done = ld_wait_req && !ld_busy;
        st_wait_done = st_wait_req && !st_busy;
    end
endmodule

// File: rtl/vmd_dma_chk.sv
// Port-level protocol checker for vmd_dma, bound to every instance.
module vmd_dma_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ld_addr_valid,
    input logic        ld_addr_ready,
    input logic        ld_wait_req,
    input logic        ld_wait_done,
    input logic        st_addr_valid,
    input logic        st_addr_ready,
    input logic        st_wait_req,
    input logic        st_wait_done,
    input logic        ext_req,
    input logic        ext_we,
    input logic [31:0] ext_addr,
    input logic        ext_ack
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !ext_req && ld_addr_ready && st_addr_ready);

    // R7
    ld_accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_addr_valid && ld_addr_ready |=> !ld_addr_ready);

    // R7
    st_accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_addr_valid && st_addr_ready |=> !st_addr_ready);

    // R8
    ld_wait_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_wait_done |-> ld_wait_req && ld_addr_ready);

    // R8
    st_wait_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_wait_done |-> st_wait_req && st_addr_ready);

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_req && !ext_ack |=> ext_req && $stable(ext_addr) && $stable(ext_we));

    // R9
    ack_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_req && ext_ack |=> !ext_req);

    // R10
    dir_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_req |-> (ext_we ? !st_addr_ready : !ld_addr_ready));
endmodule

bind vmd_dma vmd_dma_chk chk_i (
    .clk(clk), .rst_n(rst_n),
    .ld_addr_valid(ld_addr_valid), .ld_addr_ready(ld_addr_ready),
    .ld_wait_req(ld_wait_req), .ld_wait_done(ld_wait_done),
    .st_addr_valid(st_addr_valid), .st_addr_ready(st_addr_ready),
    .st_wait_req(st_wait_req), .st_wait_done(st_wait_done),
    .ext_req(ext_req), .ext_we(ext_we), .ext_addr(ext_addr), .ext_ack(ext_ack));

// File: tb/vmd_dma_tb_top.sv
module vmd_dma_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int EXT_WORDS  = 4096;
    localparam int LOG_MAX    = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_setup_valid = 0, st_setup_valid = 0;
    logic [31:0] ld_setup_data = 0, st_setup_data = 0;
    logic        ld_addr_valid = 0, st_addr_valid = 0;
    logic [31:0] ld_addr_data = 0, st_addr_data = 0;
    logic        ld_addr_ready, st_addr_ready;
    logic        ld_wait_req = 0, st_wait_req = 0;
    logic        ld_wait_done, st_wait_done;
    logic        core_rd_en = 0, core_wr_en = 0;
    logic [31:0] core_rd_data, core_wr_data = 0;
    logic        ext_req, ext_we, ext_ack = 0;
    logic [31:0] ext_addr, ext_wdata, ext_rdata = 0;

    logic [31:0] ext_mem [EXT_WORDS];
    logic [31:0] log_addr [LOG_MAX];
    logic [31:0] log_data [LOG_MAX];
    logic        log_we   [LOG_MAX];
    int          log_n = 0;
    int          ack_lag = 0;
    int          n_cmp = 0, n_bad = 0;
    bit          done = 0;

    vmd_dma dut_i (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] pat(int r, int c);
        return 32'h5A00_0000 | 32'(r << 8) | 32'(c);
    endfunction
    function automatic logic [31:0] ext_init(int i);
        return 32'hC000_0000 + 32'(i * 7);
    endfunction
    function automatic logic [31:0] dma_word(int r0, int c0, int nr, int nc);
        return 32'h8000_0000 | 32'((nc - 1) << 16) | 32'((nr - 1) << 10) | 32'(c0 << 6) | 32'(r0);
    endfunction
    function automatic logic [31:0] ptr_word(int r, int c, bit along_row, int stp);
        return 32'((stp << 11) | (int'(along_row) << 10) | (c << 6) | r);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // External memory responder: acks after ack_lag cycles, logs each word.
    initial begin
        for (int i = 0; i < EXT_WORDS; i++) ext_mem[i] = ext_init(i);
        forever begin
            int lag;
            @(negedge clk);
            if (ext_req && !ext_ack) begin
                if (lag >= ack_lag) begin
                    ext_ack   = 1'b1;
                    ext_rdata = ext_mem[ext_addr[13:2]];
                    if (ext_we) ext_mem[ext_addr[13:2]] = ext_wdata;
                    if (log_n < LOG_MAX) begin
                        log_addr[log_n] = ext_addr;
                        log_data[log_n] = ext_wdata;
                        log_we[log_n]   = ext_we;
                    end
                    log_n++;
                    lag = 0;
                end else lag++;
            end else begin
                ext_ack = 1'b0;
            end
        end
    end

    task automatic ld_setup(input logic [31:0] w);
        @(negedge clk); ld_setup_valid = 1; ld_setup_data = w;
        @(negedge clk); ld_setup_valid = 0;
    endtask
    task automatic st_setup(input logic [31:0] w);
        @(negedge clk); st_setup_valid = 1; st_setup_data = w;
        @(negedge clk); st_setup_valid = 0;
    endtask
    task automatic core_write(input logic [31:0] d);
        @(negedge clk); core_wr_en = 1; core_wr_data = d;
        @(negedge clk); core_wr_en = 0;
    endtask
    task automatic core_read(input string req, input logic [31:0] exp);
        @(negedge clk); chk(req, core_rd_data, exp); core_rd_en = 1;
        @(negedge clk); core_rd_en = 0;
    endtask
    task automatic ld_start(input logic [31:0] a, output int n_at);
        bit acc;
        @(negedge clk); ld_addr_valid = 1; ld_addr_data = a;
        forever begin
            acc = ld_addr_ready; n_at = log_n;
            @(posedge clk);
            if (acc) break;
            @(negedge clk);
        end
        @(negedge clk); ld_addr_valid = 0;
    endtask
    task automatic st_start(input logic [31:0] a);
        bit acc;
        @(negedge clk); st_addr_valid = 1; st_addr_data = a;
        forever begin
            acc = st_addr_ready;
            @(posedge clk);
            if (acc) break;
            @(negedge clk);
        end
        @(negedge clk); st_addr_valid = 0;
    endtask
    task automatic ld_wait();
        @(negedge clk); ld_wait_req = 1;
        while (!ld_wait_done) @(negedge clk);
        ld_wait_req = 0;
    endtask
    task automatic st_wait();
        @(negedge clk); st_wait_req = 1;
        while (!st_wait_done) @(negedge clk);
        st_wait_req = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int n_at;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 ext_req", 32'(ext_req), 0);
        chk("R1 ld_ready", 32'(ld_addr_ready), 1);
        chk("R1 st_ready", 32'(st_addr_ready), 1);
        rst_n = 1;
        // R1: default pointer writes along row 0 from column 0 with step 1
        core_write(32'h1111_0000); core_write(32'h1111_0001);
        core_read("R1 default rd ptr", 32'h1111_0000);
        core_read("R1 default rd step", 32'h1111_0001);

        // R3: fill every row along the row
        for (int r = 0; r < 64; r++) begin
            st_setup(ptr_word(r, 0, 1'b1, 1));
            for (int c = 0; c < 16; c++) core_write(pat(r, c));
        end
        // R4: sweep every column downwards
        for (int c = 0; c < 16; c++) begin
            ld_setup(ptr_word(0, c, 1'b0, 1));
            for (int r = 0; r < 64; r++) core_read("R4 column sweep", pat(r, c));
        end
        // R3: row mode step 3 with column wrap
        ld_setup(ptr_word(5, 14, 1'b1, 3));
        for (int k = 0; k < 6; k++) core_read("R3 row step wrap", pat(5, (14 + 3 * k) % 16));
        // R4: column mode step 5 with row wrap
        ld_setup(ptr_word(60, 2, 1'b0, 5));
        core_read("R4 col step wrap", pat(60, 2));
        core_read("R4 col step wrap", pat(1, 2));
        // R2: a DMA stride word leaves the read pointer untouched
        ld_setup(32'hC000_0005);
        core_read("R2 ptr kept", pat(6, 2));
        core_read("R2 ptr kept", pat(11, 2));

        // R5 R6: store, default stride 0, column wrap
        log_n = 0;
        st_setup(dma_word(10, 13, 3, 5));
        st_start(32'h100);
        @(negedge clk);
        chk("R7 st busy not ready", 32'(st_addr_ready), 0);
        st_wait_req = 1; #1;
        chk("R8 wait held", 32'(st_wait_done), 0);
        st_wait_req = 0;
        st_wait();
        chk("R5 store count", 32'(log_n), 15);
        for (int r = 0; r < 3; r++)
            for (int c = 0; c < 5; c++) begin
                chk("R6 store addr", log_addr[r*5+c], 32'(32'h100 + r*20 + c*4));
                chk("R10 store data", log_data[r*5+c], pat((10 + r) % 64, (13 + c) % 16));
            end

        // R6 R12: store with stride 12 and row wrap; config rewritten mid-flight
        log_n = 0;
        st_setup(dma_word(62, 13, 3, 5));
        st_setup(32'hC000_000C);
        st_start(32'h200);
        st_setup(dma_word(0, 0, 1, 1));
        st_wait();
        chk("R12 count kept", 32'(log_n), 15);
        for (int r = 0; r < 3; r++)
            for (int c = 0; c < 5; c++) begin
                chk("R6 stride addr", log_addr[r*5+c], 32'(32'h200 + r*32 + c*4));
                chk("R5 row wrap data", log_data[r*5+c], pat((62 + r) % 64, (13 + c) % 16));
            end

        // R6 R7 R2: load with stride 8 and lag; second address held back
        log_n = 0;
        ack_lag = 2;
        ld_setup(dma_word(62, 14, 4, 3));
        ld_setup(32'hC000_0008);
        ld_setup(ptr_word(0, 0, 1'b1, 1));
        ld_start(32'h800, n_at);
        ld_start(32'h900, n_at);
        chk("R7 held until done", 32'(n_at), 12);
        ld_wait();
        chk("R7 total loads", 32'(log_n), 24);
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 3; c++) begin
                chk("R6 load addr", log_addr[r*3+c], 32'(32'h800 + r*20 + c*4));
                chk("R2 load addr 2", log_addr[12+r*3+c], 32'(32'h900 + r*20 + c*4));
            end
        for (int r = 0; r < 4; r++) begin
            ld_setup(ptr_word((62 + r) % 64, 14, 1'b1, 1));
            for (int c = 0; c < 3; c++)
                core_read("R10 load data", ext_init((32'h900 + r*20 + c*4) >> 2));
        end

        // R11: simultaneous start, loads served first
        log_n = 0;
        ack_lag = 0;
        @(negedge clk);
        ld_addr_valid = 1; ld_addr_data = 32'hA00;
        st_addr_valid = 1; st_addr_data = 32'h300;
        @(negedge clk);
        ld_addr_valid = 0; st_addr_valid = 0;
        ld_wait(); st_wait();
        chk("R11 total", 32'(log_n), 13);
        for (int k = 0; k < 12; k++) chk("R11 load first", 32'(log_we[k]), 0);
        chk("R11 store last", 32'(log_we[12]), 1);
        chk("R11 store addr", log_addr[12], 32'h300);
        finish_run();
    end
endmodule